// File: doc/BRIEF.md
# Per-Pin GPIO Bank with LED Blinker and Edge Interrupts

This block runs a bank of general-purpose pins. Every pin owns one small control register with a three-bit mode field, a direction bit and a data bit. When the direction bit is clear, the pin drives. It can drive a fixed low, a blink at one of seven rates taken from a free-running prescaler, or one of eight host-written 8-bit pulse trains that shift out slot by slot. When the direction bit is set, the pin is an input. Its level passes through a two-flop synchronizer and a stability filter, and the mode field then selects which edge raises an interrupt.

All interrupts share one active-low line. A status register gives the host the address of the control register whose pin fired. If several pins are waiting, the lowest-numbered pin is reported first, and reading the status register clears that pin. The host uses a plain register port with single-cycle writes. Read data is registered and appears the cycle after the read strobe.

Address map: pin control registers sit at addresses 0..NPIN-1. Pulse-train registers 0..7 sit at NPIN..NPIN+7. The status register sits at NPIN+8.

Top module: `gpled_bank`

## Requirements
- R1: After reset every pin is an input (pin_oe low), irq_n is high, and a control register reads 8'h03 while its pin is held high: mode 0, direction 1, data shows the pin.
- R2: A control register holds the mode in bits 4:2, the direction in bit 1 and the data in bit 0, and reads back the same bits. When direction is 0, pin_oe is high. With mode 000, data 0 drives a steady low and data 1 plays pulse train 0, which resets to 8'hFF (steady high).
- R3: When direction is 1, bit 0 of a control read returns the synchronized pin level, not the stored data bit.
- R4: When direction is 0, data is 0 and mode is n (1..7), pin_out equals bit n+FLASH_K-1 of the count of clock cycles since reset, so the blink period is 2^(n+FLASH_K) cycles.
- R5: When direction is 0, data is 1 and mode is n, pin_out equals bit s of pulse train n, where s = (cycles since reset >> FLASH_K) mod 8. Pulse train n is read and written at address NPIN+n.
- R6: A new input level is accepted only after the synchronized level has differed from the accepted level for 4 consecutive cycles. Shorter pulses raise no interrupt.
- R7: In input mode the mode field selects the interrupting edge: 001 rising, 010 falling, 011 both, and 000 or 1xx none.
- R8: irq_n is low while any pin is pending. Reading address NPIN+8 returns {1'b1, 2'b00, pin address[4:0]} and clears that pin. With nothing pending it returns 8'h00.
- R9: When several pins are pending, the status read reports the lowest-numbered pin first.
- R10: A pin in output mode never raises an interrupt, whatever its input level does.
- R11: Holding data at 0 with mode 000 and toggling the direction bit gives open-drain behaviour: pin_oe follows the inverse of the direction bit while pin_out stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after rd_en |
| pin_in | input | NPIN | Pin levels seen at the pads |
| pin_out | output | NPIN | Level each pin drives when enabled |
| pin_oe | output | NPIN | Driver enable per pin |
| irq_n | output | 1 | Shared active-low interrupt |

## Verification
Output modes are checked by sampling pin_out every cycle against a cycle count kept by the bench. All seven blink rates and seven random pulse trains are covered, which separates a wrong prescaler tap from a wrong slot order. Input pulses of random width, from 1 to 7 cycles, are applied under random edge modes. This separates pulses the filter should accept from those it should reject, and edge modes that interrupt from those that do not. Directed cases cover simultaneous events on two pins, the exact cycle the interrupt appears, an empty status read, and an input toggling on a pin that is driving.

// File: rtl/gpled_pkg.sv
package gpled_pkg;

  typedef struct packed {
    logic [2:0] fsel;
    logic       dir_in;
    logic       dat;
  } pinctl_t;

  localparam pinctl_t CTL_RESET = '{fsel: 3'b000, dir_in: 1'b1, dat: 1'b1};

  // edge decode in input mode
  function automatic logic edge_hit(input logic [2:0] fsel, input logic rise, input logic fall);
    case (fsel)
      3'b001:  return rise;
      3'b010:  return fall;
      3'b011:  return rise | fall;
      default: return 1'b0;
    endcase
  endfunction

  // blink level for rate n
  function automatic logic flash_level(input logic [31:0] cnt, input logic [2:0] n,
                                       input int unsigned k);
    logic [31:0] t;
    t = cnt >> (32'(n) + k - 1);
    return t[0];
  endfunction

  // pulse train slot level
  function automatic logic train_level(input logic [7:0] pat, input logic [31:0] cnt,
                                       input int unsigned k);
    logic [31:0] t;
    t = cnt >> k;
    return pat[t[2:0]];
  endfunction

endpackage

// File: rtl/gpled_ticker.sv
module gpled_ticker #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  p_step_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/gpled_pinrx.sv
module gpled_pinrx #(
  parameter int FILT_N = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_raw,
  output logic level_sync,
  output logic level_filt,
  output logic rise,
  output logic fall
);
  localparam int FC_W = (FILT_N > 2) ? $clog2(FILT_N) : 1;

  logic            meta_q;
  logic [FC_W-1:0] run_q;
  logic            accept;

  assign accept = (level_sync != level_filt) && (run_q == FC_W'(FILT_N - 1));
  assign rise   = accept & level_sync;
  assign fall   = accept & ~level_sync;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q     <= 1'b1;
      level_sync <= 1'b1;
      level_filt <= 1'b1;
      run_q      <= '0;
    end else begin
      meta_q     <= pin_raw;
      level_sync <= meta_q;
      if (level_sync == level_filt) begin
        run_q <= '0;
      end else if (accept) begin
        level_filt <= level_sync;
        run_q      <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  p_filt_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (level_filt != $past(level_filt)) |->
      ($past(level_sync) == level_filt && $past(level_sync, 2) == level_filt));

  p_accept_moves_r7: assert property (@(posedge clk) disable iff (rst)
    (rise || fall) |=> (level_filt != $past(level_filt)));
endmodule

// File: rtl/gpled_irqsel.sv
module gpled_irqsel #(
  parameter int NPIN  = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPIN-1:0]  set_vec,
  input  logic             rd_stat,
  output logic             pend_any,
  output logic [IDX_W-1:0] pend_idx
);
  logic [NPIN-1:0] pend;
  logic [NPIN-1:0] clr_vec;

  always_comb begin
    pend_idx = '0;
    for (int i = NPIN - 1; i >= 0; i--)
      if (pend[i]) pend_idx = IDX_W'(i);
  end

  assign pend_any = |pend;

  always_comb begin
    clr_vec = '0;
    if (rd_stat && pend_any) clr_vec[pend_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend & ~clr_vec) | set_vec;
  end

  generate
    for (genvar g = 0; g < NPIN; g++) begin : g_chk
      p_pend_src_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(pend[g]) |-> $past(set_vec[g]));
    end
  endgenerate

  p_one_clear_r9: assert property (@(posedge clk) disable iff (rst)
    ($countones(pend) + 1) >= $past($countones(pend)));

  p_low_first_r9: assert property (@(posedge clk) disable iff (rst)
    pend_any |-> (pend[pend_idx] && ((pend & ((NPIN'(1) << pend_idx) - 1'b1)) == '0)));
endmodule

// File: rtl/gpled_bank.sv
module gpled_bank
  import gpled_pkg::*;
#(
  parameter int NPIN    = 8,
  parameter int FLASH_K = 2,
  parameter int FILT_N  = 4,
  localparam int AW     = $clog2(NPIN + 9)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [AW-1:0]   addr,
  input  logic [7:0]      wdata,
  output logic [7:0]      rdata,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe,
  output logic            irq_n
);
  localparam int NPAT  = 8;
  localparam int CNT_W = FLASH_K + 7;
  localparam int IDX_W = (NPIN > 1) ? $clog2(NPIN) : 1;
  localparam int STAT  = NPIN + NPAT;

  pinctl_t          ctl [NPIN];
  logic [7:0]       pat [NPAT];
  logic [CNT_W-1:0] cnt;
  logic [NPIN-1:0]  lvl_sync, lvl_filt, ev_rise, ev_fall, set_vec;
  logic             pend_any, rd_stat;
  logic [IDX_W-1:0] pend_idx;
  logic [7:0]       rd_mux;

  gpled_ticker #(.CNT_W(CNT_W)) u_tick (.clk(clk), .rst(rst), .cnt(cnt));

  generate
    for (genvar g = 0; g < NPIN; g++) begin : g_pin
      gpled_pinrx #(.FILT_N(FILT_N)) u_rx (
        .clk(clk), .rst(rst), .pin_raw(pin_in[g]),
        .level_sync(lvl_sync[g]), .level_filt(lvl_filt[g]),
        .rise(ev_rise[g]), .fall(ev_fall[g]));

      assign set_vec[g] = ctl[g].dir_in & edge_hit(ctl[g].fsel, ev_rise[g], ev_fall[g]);
      assign pin_oe[g]  = ~ctl[g].dir_in;
      assign pin_out[g] = ctl[g].dat
                        ? train_level(pat[ctl[g].fsel], 32'(cnt), FLASH_K)
                        : ((ctl[g].fsel == 3'b000) ? 1'b0
                                                   : flash_level(32'(cnt), ctl[g].fsel, FLASH_K));
    end
  endgenerate

  assign rd_stat = rd_en && (addr == AW'(STAT));

  gpled_irqsel #(.NPIN(NPIN), .IDX_W(IDX_W)) u_irq (
    .clk(clk), .rst(rst), .set_vec(set_vec), .rd_stat(rd_stat),
    .pend_any(pend_any), .pend_idx(pend_idx));

  assign irq_n = ~pend_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPIN; i++) ctl[i] <= CTL_RESET;
      for (int j = 0; j < NPAT; j++) pat[j] <= (j == 0) ? 8'hFF : 8'h00;
    end else if (wr_en) begin
      for (int i = 0; i < NPIN; i++)
        if (addr == AW'(i)) ctl[i] <= pinctl_t'(wdata[4:0]);
      for (int j = 0; j < NPAT; j++)
        if (addr == AW'(NPIN + j)) pat[j] <= wdata;
    end
  end

  always_comb begin
    rd_mux = 8'h00;
    for (int i = 0; i < NPIN; i++)
      if (addr == AW'(i))
        rd_mux = {3'b000, ctl[i].fsel, ctl[i].dir_in,
                  ctl[i].dir_in ? lvl_sync[i] : ctl[i].dat};
    for (int j = 0; j < NPAT; j++)
      if (addr == AW'(NPIN + j)) rd_mux = pat[j];
    if (addr == AW'(STAT))
      rd_mux = pend_any ? {1'b1, 2'b00, 5'(pend_idx)} : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= 8'h00;
    else if (rd_en) rdata <= rd_mux;
  end

  p_empty_status_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_stat && !pend_any) |=> rdata == 8'h00);

  p_status_form_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_stat && pend_any) |=> (rdata[7] && rdata[6:5] == 2'b00));
endmodule

// File: tb/gpled_bank_test.sv
module gpled_bank_test;
  localparam int NPIN = 8, K = 2, STAT = 16, AW = 5;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [NPIN-1:0] pin_in = '1, pin_out, pin_oe;
  logic irq_n;
  int total = 0, bad = 0;
  logic [31:0] cyc = 0;
  logic [7:0] pats [8];

  always #2 clk = ~clk;

  gpled_bank uut (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq_n(irq_n));

  always @(posedge clk) if (rst) cyc <= 0; else cyc <= cyc + 1;

  function automatic logic m_flash(input logic [31:0] c, input int n);
    return c[n + K - 1];
  endfunction
  function automatic logic m_train(input logic [7:0] p, input logic [31:0] c);
    return p[(c / (1 << K)) % 8];
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = AW'(a);
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int err;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(pin_oe == '0, "R1 oe", pin_oe, 0);
    check(irq_n == 1'b1, "R1 irq", irq_n, 1);
    rd(0, d); check(d == 8'h03, "R1 ctl0", d, 8'h03);
    // R3 live level on input
    pin_in[2] = 1'b0; idle(3);
    rd(2, d); check(d == 8'h02, "R3 live pin", d, 8'h02);
    pin_in[2] = 1'b1; idle(8);
    // R2 output static
    wr(1, 8'h00);
    check(pin_oe[1] && !pin_out[1], "R2 drive low", {pin_oe[1], pin_out[1]}, 2);
    rd(1, d); check(d == 8'h00, "R2 readback", d, 0);
    wr(1, 8'h01);
    check(pin_out[1] == 1'b1, "R2 train0 high", pin_out[1], 1);
    wr(1, 8'h15); rd(1, d); check(d == 8'h15, "R2 field layout", d, 8'h15);
    // R11 open-drain by direction toggling
    wr(1, 8'h02);
    check(!pin_oe[1], "R11 released", pin_oe[1], 0);
    wr(1, 8'h00);
    check(pin_oe[1] && !pin_out[1], "R11 pull low", {pin_oe[1], pin_out[1]}, 2);
    // R4 flash rates
    for (int n = 1; n < 8; n++) begin
      wr(3, 8'(n << 2));
      err = 0;
      for (int s = 0; s < 40; s++) begin
        @(negedge clk);
        if (pin_out[3] !== m_flash(cyc, n)) err++;
      end
      check(err == 0, "R4 flash rate", err, 0);
    end
    // R5 pulse trains
    for (int n = 1; n < 8; n++) begin
      pats[n] = 8'($urandom);
      wr(8 + n, pats[n]);
      rd(8 + n, d); check(d == pats[n], "R5 pattern readback", d, pats[n]);
      wr(4, 8'((n << 2) | 1));
      err = 0;
      for (int s = 0; s < 64; s++) begin
        @(negedge clk);
        if (pin_out[4] !== m_train(pats[n], cyc)) err++;
      end
      check(err == 0, "R5 train output", err, 0);
    end
    // R6 R8 falling edge timing on pin 5
    wr(5, 8'h0B);
    pin_in[5] = 1'b0;
    idle(5); check(irq_n == 1'b1, "R6 filter delay", irq_n, 1);
    idle(1); check(irq_n == 1'b0, "R8 irq asserted", irq_n, 0);
    rd(STAT, d); check(d == 8'h85, "R8 status pin5", d, 8'h85);
    check(irq_n == 1'b1, "R8 cleared", irq_n, 1);
    // R7 rising edge ignored in falling mode
    pin_in[5] = 1'b1; idle(10);
    check(irq_n == 1'b1, "R7 rise ignored", irq_n, 1);
    // R6 glitch rejected, 4-cycle pulse accepted
    pin_in[5] = 1'b0; idle(3); pin_in[5] = 1'b1; idle(10);
    check(irq_n == 1'b1, "R6 glitch", irq_n, 1);
    pin_in[5] = 1'b0; idle(4); pin_in[5] = 1'b1; idle(10);
    check(irq_n == 1'b0, "R6 four cycles", irq_n, 0);
    rd(STAT, d); check(d == 8'h85, "R6 status", d, 8'h85);
    // R9 priority
    wr(6, 8'h0B); wr(2, 8'h0B);
    pin_in[6] = 1'b0; pin_in[2] = 1'b0; idle(8);
    rd(STAT, d); check(d == 8'h82, "R9 lowest first", d, 8'h82);
    check(irq_n == 1'b0, "R9 still pending", irq_n, 0);
    rd(STAT, d); check(d == 8'h86, "R9 second", d, 8'h86);
    rd(STAT, d); check(d == 8'h00, "R8 empty", d, 0);
    pin_in[6] = 1'b1; pin_in[2] = 1'b1; idle(8);
    // R10 output pin ignores input toggling
    wr(7, 8'h0C);
    pin_in[7] = 1'b0; idle(10); pin_in[7] = 1'b1; idle(10);
    check(irq_n == 1'b1, "R10 no irq", irq_n, 1);
    rd(STAT, d); check(d == 8'h00, "R10 status", d, 0);
    // random pulses, R6 R7 R8
    for (int it = 0; it < 30; it++) begin
      int p, m, len;
      logic exp_irq;
      p = $urandom % NPIN; m = $urandom % 8; len = 1 + ($urandom % 7);
      wr(p, 8'((m << 2) | 3)); idle(8);
      pin_in[p] = 1'b0; idle(len); pin_in[p] = 1'b1; idle(12);
      exp_irq = (len >= 4) && (m >= 1) && (m <= 3);
      check(irq_n == !exp_irq, "R7 random irq", irq_n, !exp_irq);
      rd(STAT, d);
      check(d == (exp_irq ? 8'(8'h80 | p) : 8'h00), "R8 random status", d,
            exp_irq ? (8'h80 | p) : 0);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule